// File: doc/BRIEF.md
# Lockable Two-Way Data Cache

This block is a small data cache placed between a 32-bit load/store port and a word-wide backing memory. It holds 4 Kbytes as two ways of 128 sets, with 16-byte lines, and works on physical addresses only. A read that hits returns cached data without touching memory. A read that misses fetches the whole line, starting at the requested word and wrapping around. The requested word is returned as soon as it arrives. The line to replace is picked by a per-set least-recently-used bit.

Software can pin individual lines with a lock command. The victim choice never takes a locked line. When both ways of the indexed set are locked, a read miss is served straight from memory and nothing is allocated. Writes always go through to memory. A write that hits also updates the cached word, and a write that misses allocates nothing. An invalidate command drops a line's validity but keeps its lock, and an unlock command releases the lock.

The cache takes one command at a time. A command is accepted on a clock edge where `req_valid` and `req_ready` are both high. Every accepted command produces exactly one single-cycle `resp_valid` pulse.

Top module: `lockcache_top`

## Requirements
- R1: After reset, `req_ready` is high, `resp_valid` and `mem_req` are low, and every line is invalid and unlocked, so the first access to any address is a miss.
- R2: A read (command code 0) of a valid resident line raises `resp_valid` exactly two cycles after the accepting edge. It returns the word with `resp_hit`=1 and issues no memory request.
- R3: The address splits into word = bits [3:2], set = bits [10:4] and tag = bits [31:11]. A read miss fetches the four words of the line in wrap order, starting at the requested word. It returns the requested word, with `resp_hit`=0, in the cycle after that word's `mem_ack`. The line is valid once the fill ends.
- R4: Each set keeps one LRU bit. Every hit and every fill sets it to point at the way not just used, and an unlocked victim is the way it points to.
- R5: A lock command (code 3) that hits sets the line's lock bit. On a miss with an unlocked way available, it fills the line as a read does and then locks it, responding after the fill. A locked line is never chosen as a victim.
- R6: When both ways of the set are locked, a read miss makes one memory read of the requested word and returns it. Nothing is allocated, so a repeated read misses again. A lock command in this case does nothing.
- R7: A write (command code 1) makes exactly one memory write. On a hit, the cached word is updated as well. On a miss, no line is allocated.
- R8: The invalidate command (code 2) clears the valid bit of a hitting line and leaves its lock bit set, so that way stays reserved.
- R9: The unlock command (code 4) clears the lock bit of every way in the set whose tag matches, valid or not, and the way becomes a candidate victim again.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack`. Only one memory transfer is outstanding at a time.
- R11: `req_ready` is low from the accepting edge until the command completes. Each command gives one `resp_valid` pulse. `resp_hit` reports whether a valid tag matched at lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Cache idle, command accepted this edge |
| req_cmd | input | 3 | 0 read, 1 write, 2 invalidate, 3 lock, 4 unlock |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Valid tag matched at lookup |
| resp_rdata | output | 32 | Read data (reads only) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Transfer done, read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Every result falls due at a fixed cycle after the accepting edge:
- Hits, invalidates, unlocks and refused locks respond on the second cycle.
- A command that waits on a single memory transfer responds on the cycle after its acknowledge. With the bench memory acknowledging on the second cycle of each request, that is the fourth cycle.
- A lock fill responds on the thirteenth cycle.

The bench samples at the falling edge and predicts the exact response cycle, the hit flag and the read data for each command. It also predicts the full list of memory transfers, and it checks that `req_ready` stays low and that no second pulse appears until the cache is idle again.

// File: rtl/lc_pkg.sv
package lc_pkg;
   typedef enum logic [2:0] {
      CMD_READ   = 3'd0,
      CMD_WRITE  = 3'd1,
      CMD_INVAL  = 3'd2,
      CMD_LOCK   = 3'd3,
      CMD_UNLOCK = 3'd4
   } lc_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_FILL,
      ST_BYP,
      ST_WR
   } lc_state_e;
endpackage

// File: rtl/lc_tag_store.sv
module lc_tag_store #(
   parameter int N_SETS = 128,
   parameter int TAG_W  = 21,
   localparam int IDX_W = $clog2(N_SETS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      idx,
   output logic [1:0][TAG_W-1:0] rd_tag,
   output logic [1:0]            rd_valid,
   output logic [1:0]            rd_lock,
   output logic                  rd_lru,
   input  logic                  lru_we,
   input  logic                  lru_used,
   input  logic                  fill_we,
   input  logic                  fill_way,
   input  logic [TAG_W-1:0]      fill_tag,
   input  logic                  fill_lock,
   input  logic                  inval_we,
   input  logic                  inval_way,
   input  logic                  lock_set_we,
   input  logic                  lock_way,
   input  logic [1:0]            unlock_mask
);
   logic [N_SETS-1:0] lru_q;

   for (genvar w = 0; w < 2; w++) begin : g_way
      logic [TAG_W-1:0]  tags [N_SETS];
      logic [N_SETS-1:0] vld_q;
      logic [N_SETS-1:0] lck_q;

      always_ff @(posedge clk) begin
         if (fill_we && fill_way == 1'(w)) tags[idx] <= fill_tag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
            lck_q <= '0;
         end else begin
            if (fill_we && fill_way == 1'(w)) begin
               vld_q[idx] <= 1'b1;
               lck_q[idx] <= fill_lock;
            end
            if (inval_we && inval_way == 1'(w)) vld_q[idx] <= 1'b0;
            if (lock_set_we && lock_way == 1'(w)) lck_q[idx] <= 1'b1;
            if (unlock_mask[w]) lck_q[idx] <= 1'b0;
         end
      end

      assign rd_tag[w]   = tags[idx];
      assign rd_valid[w] = vld_q[idx];
      assign rd_lock[w]  = lck_q[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lru_q      <= '0;
      else if (lru_we) lru_q[idx] <= ~lru_used;
   end

   assign rd_lru = lru_q[idx];

   AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
      lru_we |=> rd_lru == !$past(lru_used)); // R4
   AST_INVAL_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_we && !lock_set_we && unlock_mask == 2'b00 && !fill_we)
         |=> (rd_lock == $past(rd_lock)) && !rd_valid[$past(inval_way)]); // R8
endmodule

// File: rtl/lc_data_store.sv
module lc_data_store #(
   parameter int N_SETS     = 128,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 32,
   localparam int IDX_W = $clog2(N_SETS),
   localparam int OFF_W = $clog2(LINE_WORDS),
   localparam int DEPTH = N_SETS * LINE_WORDS
) (
   input  logic                   clk,
   input  logic [IDX_W-1:0]       idx,
   input  logic [OFF_W-1:0]       rd_word,
   output logic [1:0][DATA_W-1:0] rd_data,
   input  logic                   we,
   input  logic                   wr_way,
   input  logic [OFF_W-1:0]       wr_word,
   input  logic [DATA_W-1:0]      wr_data
);
   for (genvar w = 0; w < 2; w++) begin : g_way
      logic [DATA_W-1:0] words [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wr_way == 1'(w)) words[{idx, wr_word}] <= wr_data;
      end

      assign rd_data[w] = words[{idx, rd_word}];
   end
endmodule

// File: rtl/lc_victim.sv
module lc_victim (
   input  logic [1:0] lock,
   input  logic       lru,
   output logic       victim,
   output logic       both_locked
);
   always_comb begin
      both_locked = &lock;
      if (lock[0])      victim = 1'b1;
      else if (lock[1]) victim = 1'b0;
      else              victim = lru;
   end
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl import lc_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int N_SETS     = 128,
   parameter int LINE_WORDS = 4,
   localparam int IDX_W = $clog2(N_SETS),
   localparam int OFF_W = $clog2(LINE_WORDS),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2,
   localparam int TAG_LO = IDX_W + OFF_W + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [2:0]             req_cmd,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   resp_valid,
   output logic                   resp_hit,
   output logic [DATA_W-1:0]      resp_rdata,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic [IDX_W-1:0]       set_idx,
   output logic [OFF_W-1:0]       req_word,
   input  logic [1:0][TAG_W-1:0]  rd_tag,
   input  logic [1:0]             rd_valid,
   input  logic [1:0]             rd_lock,
   input  logic [1:0][DATA_W-1:0] rd_data,
   input  logic                   victim,
   input  logic                   both_locked,
   output logic                   lru_we,
   output logic                   lru_used,
   output logic                   fill_we,
   output logic                   fill_way,
   output logic [TAG_W-1:0]       fill_tag,
   output logic                   fill_lock,
   output logic                   inval_we,
   output logic                   inval_way,
   output logic                   lock_set_we,
   output logic                   lock_way,
   output logic [1:0]             unlock_mask,
   output logic                   dwe,
   output logic                   dway,
   output logic [OFF_W-1:0]       dword,
   output logic [DATA_W-1:0]      ddata
);
   localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

   lc_state_e         state_q;
   lc_cmd_e           cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              way_q;
   logic              hit_q;
   logic [OFF_W-1:0]  cnt_q;

   logic [TAG_W-1:0]  tag;
   logic [OFF_W-1:0]  cur_word;
   logic [1:0]        hit_vec;
   logic [1:0]        match_lock;
   logic              hit;
   logic              hit_way;
   logic              look;
   logic              fill_ack;

   assign tag      = addr_q[ADDR_W-1:TAG_LO];
   assign set_idx  = addr_q[TAG_LO-1:OFF_W+2];
   assign req_word = addr_q[OFF_W+1:2];
   assign cur_word = req_word + cnt_q;

   for (genvar w = 0; w < 2; w++) begin : g_match
      assign hit_vec[w]    = rd_valid[w] && (rd_tag[w] == tag);
      assign match_lock[w] = rd_lock[w]  && (rd_tag[w] == tag);
   end

   assign hit      = |hit_vec;
   assign hit_way  = hit_vec[1];
   assign look     = (state_q == ST_LOOK);
   assign fill_ack = (state_q == ST_FILL) && mem_ack;

   assign req_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_FILL) || (state_q == ST_BYP) || (state_q == ST_WR);
   assign mem_we    = (state_q == ST_WR);
   assign mem_wdata = wdata_q;
   assign mem_addr  = (state_q == ST_FILL) ? {tag, set_idx, cur_word, 2'b00} : addr_q;

   always_comb begin
      fill_we     = fill_ack && (cnt_q == LAST);
      fill_way    = way_q;
      fill_tag    = tag;
      fill_lock   = (cmd_q == CMD_LOCK);
      lru_we      = fill_we || (look && hit &&
                    (cmd_q == CMD_READ || cmd_q == CMD_WRITE || cmd_q == CMD_LOCK));
      lru_used    = fill_we ? way_q : hit_way;
      inval_we    = look && hit && (cmd_q == CMD_INVAL);
      inval_way   = hit_way;
      lock_set_we = look && hit && (cmd_q == CMD_LOCK);
      lock_way    = hit_way;
      unlock_mask = (look && cmd_q == CMD_UNLOCK) ? match_lock : 2'b00;
      dwe         = fill_ack || (look && hit && cmd_q == CMD_WRITE);
      dway        = fill_ack ? way_q : hit_way;
      dword       = fill_ack ? cur_word : req_word;
      ddata       = fill_ack ? mem_rdata : wdata_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cmd_q      <= CMD_READ;
         addr_q     <= '0;
         wdata_q    <= '0;
         way_q      <= 1'b0;
         hit_q      <= 1'b0;
         cnt_q      <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               cmd_q   <= lc_cmd_e'(req_cmd);
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               state_q <= ST_LOOK;
            end
            ST_LOOK: begin
               hit_q      <= hit;
               cnt_q      <= '0;
               way_q      <= victim;
               resp_hit   <= hit;
               resp_rdata <= '0;
               if (cmd_q == CMD_WRITE) begin
                  state_q <= ST_WR;
               end else if ((cmd_q == CMD_READ || cmd_q == CMD_LOCK) && !hit) begin
                  if (!both_locked)           state_q <= ST_FILL;
                  else if (cmd_q == CMD_READ) state_q <= ST_BYP;
                  else begin
                     resp_valid <= 1'b1;
                     state_q    <= ST_IDLE;
                  end
               end else begin
                  resp_valid <= 1'b1;
                  if (cmd_q == CMD_READ) resp_rdata <= rd_data[hit_way];
                  state_q    <= ST_IDLE;
               end
            end
            ST_FILL: if (mem_ack) begin
               cnt_q <= cnt_q + 1'b1;
               if (cmd_q == CMD_READ && cnt_q == '0) begin
                  resp_valid <= 1'b1;
                  resp_rdata <= mem_rdata;
               end
               if (cnt_q == LAST) begin
                  if (cmd_q == CMD_LOCK) resp_valid <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_BYP: if (mem_ack) begin
               resp_valid <= 1'b1;
               resp_rdata <= mem_rdata;
               state_q    <= ST_IDLE;
            end
            ST_WR: if (mem_ack) begin
               resp_valid <= 1'b1;
               resp_hit   <= hit_q;
               state_q    <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      look |-> $onehot0(hit_vec)); // R2
   AST_FILL_WAY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL) |-> !rd_lock[way_q]); // R5
   AST_BYPASS_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BYP) |-> (rd_lock == 2'b11)); // R6
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)); // R10
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R11
endmodule

// File: rtl/lockcache_top.sv
module lockcache_top #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int N_SETS     = 128,
   parameter int LINE_WORDS = 4,
   parameter int N_WAYS     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(N_SETS);
   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2;

   if (N_WAYS != 2) begin : g_bad_ways
      $error("lockcache_top: N_WAYS must be 2");
   end
   if ((1 << IDX_W) != N_SETS) begin : g_bad_sets
      $error("lockcache_top: N_SETS must be a power of two");
   end
   if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS) begin : g_bad_line
      $error("lockcache_top: LINE_WORDS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("lockcache_top: address too narrow for the geometry");
   end

   logic [IDX_W-1:0]       set_idx;
   logic [OFF_W-1:0]       req_word;
   logic [1:0][TAG_W-1:0]  rd_tag;
   logic [1:0]             rd_valid;
   logic [1:0]             rd_lock;
   logic                   rd_lru;
   logic [1:0][DATA_W-1:0] rd_data;
   logic                   victim;
   logic                   both_locked;
   logic                   lru_we;
   logic                   lru_used;
   logic                   fill_we;
   logic                   fill_way;
   logic [TAG_W-1:0]       fill_tag;
   logic                   fill_lock;
   logic                   inval_we;
   logic                   inval_way;
   logic                   lock_set_we;
   logic                   lock_way;
   logic [1:0]             unlock_mask;
   logic                   dwe;
   logic                   dway;
   logic [OFF_W-1:0]       dword;
   logic [DATA_W-1:0]      ddata;

   lc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SETS(N_SETS), .LINE_WORDS(LINE_WORDS)
   ) u_ctrl (
      .clk, .rst_n, .req_valid, .req_ready, .req_cmd, .req_addr, .req_wdata,
      .resp_valid, .resp_hit, .resp_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
      .set_idx, .req_word, .rd_tag, .rd_valid, .rd_lock, .rd_data,
      .victim, .both_locked,
      .lru_we, .lru_used, .fill_we, .fill_way, .fill_tag, .fill_lock,
      .inval_we, .inval_way, .lock_set_we, .lock_way, .unlock_mask,
      .dwe, .dway, .dword, .ddata
   );

   lc_tag_store #(.N_SETS(N_SETS), .TAG_W(TAG_W)) u_tags (
      .clk, .rst_n, .idx(set_idx),
      .rd_tag, .rd_valid, .rd_lock, .rd_lru,
      .lru_we, .lru_used, .fill_we, .fill_way, .fill_tag, .fill_lock,
      .inval_we, .inval_way, .lock_set_we, .lock_way, .unlock_mask
   );

   lc_data_store #(.N_SETS(N_SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
      .clk, .idx(set_idx), .rd_word(req_word), .rd_data,
      .we(dwe), .wr_way(dway), .wr_word(dword), .wr_data(ddata)
   );

   lc_victim u_victim (
      .lock(rd_lock), .lru(rd_lru), .victim, .both_locked
   );
endmodule

// File: tb/tb_lockcache_top.sv
module tb_lockcache_top;
   localparam int NS = 128;

   typedef struct {
      int line;
      bit valid;
      bit locked;
   } ent_t;

   typedef struct {
      bit          we;
      logic [31:0] addr;
      logic [31:0] data;
   } xfer_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_cmd = 3'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        resp_valid;
   logic        resp_hit;
   logic [31:0] resp_rdata;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [31:0] mem_m [int];
   ent_t        sq [NS][$];
   xfer_t       exp_tr [$];
   xfer_t       act_tr [$];
   int          lat = 0;
   logic [31:0] prev_addr = '0;
   bit          prev_pend = 1'b0;

   always #4 clk = ~clk;

   lockcache_top dut (.*);

   function automatic logic [31:0] mread(logic [31:0] a);
      if (mem_m.exists(int'(a))) return mem_m[int'(a)];
      return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   function automatic logic [31:0] mk(int t, int s, int w);
      return {t[20:0], s[6:0], w[1:0], 2'b00};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // bench memory: acknowledges on the second cycle of each request
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
         lat = 0;
         prev_pend = 1'b0;
      end else if (mem_req) begin
         if (prev_pend)
            chk(mem_addr == prev_addr, "R10", "address held until ack", mem_addr, prev_addr);
         prev_pend = 1'b1;
         prev_addr = mem_addr;
         lat++;
         if (lat == 2) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem_m[int'(mem_addr)] = mem_wdata;
               act_tr.push_back('{1'b1, mem_addr, mem_wdata});
            end else begin
               mem_rdata <= mread(mem_addr);
               act_tr.push_back('{1'b0, mem_addr, mread(mem_addr)});
            end
         end
      end
   end

   task automatic do_op(input int cmd, input logic [31:0] a, input logic [31:0] wd,
                        output bit got_hit, output logic [31:0] got_data);
      int    s;
      int    line;
      int    hi;
      int    vi;
      int    exp_lat;
      int    n;
      bit    exp_hit;
      string rq;
      ent_t  e;
      s    = int'(a[10:4]);
      line = int'(a[31:4]);
      hi   = -1;
      vi   = -1;
      foreach (sq[s][i]) if (sq[s][i].valid && sq[s][i].line == line) hi = i;
      exp_hit = (hi >= 0);
      if (!sq[s][0].locked) vi = 0;
      else if (!sq[s][1].locked) vi = 1;
      exp_tr.delete();
      act_tr.delete();
      exp_lat = 2;
      rq = "R11";
      case (cmd)
         0: begin
            if (exp_hit) begin
               rq = "R2";
               e = sq[s][hi]; sq[s].delete(hi); sq[s].push_back(e);
            end else if (vi < 0) begin
               rq = "R6"; exp_lat = 4;
               exp_tr.push_back('{1'b0, a, mread(a)});
            end else begin
               rq = "R3"; exp_lat = 4;
               for (int k = 0; k < 4; k++) begin
                  logic [31:0] fa;
                  fa = {a[31:4], 2'(a[3:2] + k[1:0]), 2'b00};
                  exp_tr.push_back('{1'b0, fa, mread(fa)});
               end
               sq[s].delete(vi); sq[s].push_back('{line, 1'b1, 1'b0});
            end
         end
         1: begin
            rq = "R7"; exp_lat = 4;
            exp_tr.push_back('{1'b1, a, wd});
            if (exp_hit) begin
               e = sq[s][hi]; sq[s].delete(hi); sq[s].push_back(e);
            end
         end
         2: begin
            rq = "R8";
            if (exp_hit) sq[s][hi].valid = 1'b0;
         end
         3: begin
            rq = "R5";
            if (exp_hit) begin
               e = sq[s][hi]; e.locked = 1'b1; sq[s].delete(hi); sq[s].push_back(e);
            end else if (vi >= 0) begin
               exp_lat = 13;
               for (int k = 0; k < 4; k++) begin
                  logic [31:0] fa;
                  fa = {a[31:4], 2'(a[3:2] + k[1:0]), 2'b00};
                  exp_tr.push_back('{1'b0, fa, mread(fa)});
               end
               sq[s].delete(vi); sq[s].push_back('{line, 1'b1, 1'b1});
            end
         end
         default: begin
            rq = "R9";
            foreach (sq[s][i]) if (sq[s][i].line == line) sq[s][i].locked = 1'b0;
         end
      endcase

      req_cmd   = 3'(cmd);
      req_addr  = a;
      req_wdata = wd;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!resp_valid && n < 40) begin
         chk(!req_ready, "R11", "ready low while busy", 32'(req_ready), 0);
         @(negedge clk);
         n++;
      end
      chk(n == exp_lat, rq, "response cycle", n, exp_lat);
      chk(resp_hit == exp_hit, rq, "hit flag", 32'(resp_hit), 32'(exp_hit));
      got_hit  = resp_hit;
      got_data = resp_rdata;
      if (cmd == 0) chk(resp_rdata == mread(a), rq, "read data", resp_rdata, mread(a));
      n = 0;
      while (!req_ready && n < 40) begin
         @(negedge clk);
         n++;
         chk(!resp_valid, "R11", "single response pulse", 32'(resp_valid), 0);
      end
      chk(act_tr.size() == exp_tr.size(), rq, "memory transfer count",
          act_tr.size(), exp_tr.size());
      if (act_tr.size() == exp_tr.size())
         foreach (exp_tr[i]) begin
            chk(act_tr[i].we == exp_tr[i].we && act_tr[i].addr == exp_tr[i].addr
                && act_tr[i].data == exp_tr[i].data, rq, "memory transfer",
                act_tr[i].addr, exp_tr[i].addr);
         end
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      if (!done) begin
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit          h;
      logic [31:0] d;
      for (int s = 0; s < NS; s++) begin
         sq[s].push_back('{-1, 1'b0, 1'b0});
         sq[s].push_back('{-1, 1'b0, 1'b0});
      end
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 1);
      chk(resp_valid == 1'b0 && mem_req == 1'b0, "R1", "idle outputs in reset",
          {resp_valid, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && mem_req == 1'b0, "R1", "idle after reset", 32'(req_ready), 1);

      // R1 / R3: first access misses and fills in wrap order from word 2
      do_op(0, mk(1, 5, 2), 0, h, d);
      chk(!h, "R1", "first access misses", 32'(h), 0);
      do_op(0, mk(1, 5, 0), 0, h, d);
      chk(h, "R3", "line valid after fill", 32'(h), 1);
      // R4: LRU victim choice
      do_op(0, mk(2, 5, 1), 0, h, d);
      do_op(0, mk(1, 5, 3), 0, h, d);
      do_op(0, mk(3, 5, 0), 0, h, d);
      do_op(0, mk(1, 5, 1), 0, h, d);
      chk(h, "R4", "recently used line survives", 32'(h), 1);
      do_op(0, mk(2, 5, 1), 0, h, d);
      chk(!h, "R4", "least recent line was evicted", 32'(h), 0);
      // R7: write-through
      do_op(1, mk(2, 5, 3), 32'hCAFE_0001, h, d);
      chk(h, "R7", "write hit flagged", 32'(h), 1);
      do_op(0, mk(2, 5, 3), 0, h, d);
      chk(h && d == 32'hCAFE_0001, "R7", "write hit updates cache", d, 32'hCAFE_0001);
      do_op(1, mk(4, 5, 0), 32'h0BAD_F00D, h, d);
      do_op(0, mk(4, 5, 0), 0, h, d);
      chk(!h, "R7", "write miss does not allocate", 32'(h), 0);
      // R5 / R6: locking in set 7
      do_op(3, mk(1, 7, 0), 0, h, d);
      do_op(0, mk(2, 7, 0), 0, h, d);
      do_op(0, mk(3, 7, 2), 0, h, d);
      do_op(0, mk(1, 7, 1), 0, h, d);
      chk(h, "R5", "locked line not evicted", 32'(h), 1);
      do_op(3, mk(2, 7, 0), 0, h, d);
      do_op(0, mk(3, 7, 2), 0, h, d);
      chk(!h, "R6", "both locked read bypasses", 32'(h), 0);
      do_op(0, mk(3, 7, 2), 0, h, d);
      chk(!h, "R6", "bypass allocates nothing", 32'(h), 0);
      do_op(3, mk(5, 7, 0), 0, h, d);
      // R8: invalidate keeps the lock
      do_op(2, mk(1, 7, 0), 0, h, d);
      chk(h, "R8", "invalidate hit", 32'(h), 1);
      do_op(0, mk(1, 7, 0), 0, h, d);
      chk(!h && act_tr.size() == 1, "R8", "way still reserved", act_tr.size(), 1);
      // R9: unlock frees the way
      do_op(4, mk(1, 7, 0), 0, h, d);
      do_op(0, mk(3, 7, 0), 0, h, d);
      chk(act_tr.size() == 4, "R9", "unlocked way refilled", act_tr.size(), 4);
      do_op(0, mk(2, 7, 3), 0, h, d);
      chk(h, "R9", "other locked line kept", 32'(h), 1);

      // mixed traffic against the model
      for (int i = 0; i < 400; i++) begin
         int c;
         int r;
         r = int'($urandom_range(0, 9));
         c = (r < 5) ? 0 : (r < 7) ? 1 : (r == 7) ? 2 : (r == 8) ? 3 : 4;
         do_op(c, mk(int'($urandom_range(1, 4)), 8 + int'($urandom_range(0, 1)),
                     int'($urandom_range(0, 3))), $urandom, h, d);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule